// File: doc/BRIEF.md
# Outstanding Line Request Tracker

This block sits between a core's memory pipeline and its first-level cache controller and keeps a record of every cache-line request that has been sent and not yet answered. Reads live in one small fully associative table and store-class operations in another; each entry holds a line address, a request kind, an issue timestamp and, for reads, a count of speculative loads merged into it. Every request offered on the input gets an immediate verdict in the same cycle. It is issued into a table, merged into a pending speculative load, reported as aliased against a conflicting pending entry, or refused because the tracker is full.

Completions arrive separately for the read and write tables and free the entry with the matching line address. The completion of a locked read-modify-write read places a lock on its line. Until the matching locked write completes, only the locked write may enter for that line. An age watchdog samples the tables periodically while anything is outstanding and raises a sticky deadlock flag when some entry has waited too long. A completion that finds no matching entry raises a sticky error flag.

Top module: `line_request_tracker`

## Requirements
- R1: The request verdict on `reqStatus` is 0 issued, 1 merged, 2 aliased, 3 full. A request gets full (3) and changes nothing when the outstanding count, after this cycle's completions, is at or above MAX_OUT, or when the table it needs has no free slot.
- R2: While a line is locked, any request to that line is aliased, except one of kind 8 (locked write). Requests to other lines are unaffected.
- R3: Kinds 3 and above are store-class and go to the write table: 3 store, 4 read-modify-write, 5 load-linked, 6 store-conditional, 7 locked read, 8 locked write, 9 flush. A store-class request is aliased when a read or a write entry for the same line is pending.
- R4: Kinds 0 (load), 1 (speculative load) and 2 (fetch) are load-class and go to the read table. A load-class request is aliased when a write entry for its line is pending. It is also aliased when a read entry for its line is pending, except that a speculative load meeting a pending speculative load is merged.
- R5: A read entry accepts at most MERGE_MAX merged speculative loads; a further one is aliased.
- R6: A write completion that removes a kind-7 entry locks its line (`lineLocked` high from the next cycle). A write completion that removes a kind-8 entry for the locked line releases the lock.
- R7: `outCount` equals the number of read plus write entries. An issued request raises it by one, a merge leaves it unchanged, and a matching completion lowers it by one.
- R8: While entries are outstanding, the watchdog checks every THRESH cycles. It sets the sticky `deadlock` flag when some entry is at least THRESH cycles old, so a stuck entry is flagged within 2*THRESH+2 cycles. Entries that always complete within THRESH-2 cycles never set it.
- R9: A read or write completion whose line is not in the matching table sets the sticky `missError` flag and changes no entry.
- R10: A completion and a request in the same cycle see the completion applied first, both for the alias check and for the full check.
- R11: After reset `outCount` is 0, and `lineLocked`, `deadlock` and `missError` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is offered this cycle |
| reqAddr | input | ADDR_W | Line address of the request |
| reqKind | input | 4 | Request kind code |
| reqStatus | output | 2 | Verdict for the offered request, same cycle |
| rdDoneValid | input | 1 | Read completion this cycle |
| rdDoneAddr | input | ADDR_W | Line address of the read completion |
| wrDoneValid | input | 1 | Write completion this cycle |
| wrDoneAddr | input | ADDR_W | Line address of the write completion |
| outCount | output | CNT_W | Number of outstanding entries |
| lineLocked | output | 1 | A line is currently locked |
| deadlock | output | 1 | Sticky watchdog flag |
| missError | output | 1 | Sticky unmatched-completion flag |

## Verification
The assertions rely on the caller holding `reqStatus` as the final answer for a cycle. They also rely on completions naming only lines that the tracker reports as outstanding, so that no line ever has two entries in one table or entries in both tables. The stimulus keeps within these limits by driving each request and completion for exactly one cycle, with a reset before every sweep case. Unmatched completions are sent only on purpose, in the error-flag test. The sweep covers every pair of pending kind and new kind on the same line and on different lines.

// File: rtl/reqtrk_pkg.sv
package reqtrk_pkg;

  typedef enum logic [3:0] {
    K_LOAD   = 4'd0,
    K_SPEC   = 4'd1,
    K_FETCH  = 4'd2,
    K_STORE  = 4'd3,
    K_RMW    = 4'd4,
    K_LINK   = 4'd5,
    K_COND   = 4'd6,
    K_LOCKRD = 4'd7,
    K_LOCKWR = 4'd8,
    K_FLUSH  = 4'd9
  } kind_e;

  typedef enum logic [1:0] {
    ST_ISSUED  = 2'd0,
    ST_MERGED  = 2'd1,
    ST_ALIASED = 2'd2,
    ST_FULL    = 2'd3
  } status_e;

  typedef struct packed {
    logic allocRd;
    logic allocWr;
    logic mergeRd;
    logic freeRd;
    logic freeWr;
  } strobe_t;

  function automatic logic isStoreClass(kind_e k);
    return k >= K_STORE;
  endfunction

endpackage

// File: rtl/reqtrk_table.sv
module reqtrk_table
  import reqtrk_pkg::*;
#(
  parameter int ADDR_W    = 26,
  parameter int RD_N      = 8,
  parameter int WR_N      = 8,
  parameter int MERGE_MAX = 4,
  parameter int THRESH    = 500000,
  parameter int CNT_W     = $clog2(RD_N + WR_N + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  kind_e             reqKind,
  input  logic              rdDoneValid,
  input  logic [ADDR_W-1:0] rdDoneAddr,
  input  logic              wrDoneValid,
  input  logic [ADDR_W-1:0] wrDoneAddr,
  output logic              rdHit,
  output logic              rdHitSpec,
  output logic              rdHitMergeFull,
  output logic              wrHit,
  output logic              rdHasFree,
  output logic              wrHasFree,
  output logic              rdDoneHit,
  output logic              wrDoneHit,
  output kind_e             wrDoneKind,
  output logic              anyStale,
  output logic [CNT_W-1:0]  validCount
);

  localparam int TS_W = $clog2(THRESH) + 3;
  localparam int MW   = $clog2(MERGE_MAX + 1);
  localparam int RI_W = (RD_N > 1) ? $clog2(RD_N) : 1;
  localparam int WI_W = (WR_N > 1) ? $clog2(WR_N) : 1;

  logic [RD_N-1:0]   rdV;
  logic [ADDR_W-1:0] rdA [RD_N];
  kind_e             rdK [RD_N];
  logic [TS_W-1:0]   rdT [RD_N];
  logic [MW-1:0]     rdM [RD_N];
  logic [WR_N-1:0]   wrV;
  logic [ADDR_W-1:0] wrA [WR_N];
  kind_e             wrK [WR_N];
  logic [TS_W-1:0]   wrT [WR_N];
  logic [TS_W-1:0]   nowTs;

  logic [RD_N-1:0] rdDoneVec, rdLive, rdMatch;
  logic [WR_N-1:0] wrDoneVec, wrLive, wrMatch;
  logic [RI_W-1:0] rdFreeIdx, rdHitIdx;
  logic [WI_W-1:0] wrFreeIdx;

  // Read side lookups, seen after this cycle's completion is removed
  always_comb begin
    rdHit = 1'b0; rdHasFree = 1'b0; rdFreeIdx = '0; rdHitIdx = '0;
    for (int i = 0; i < RD_N; i++) begin
      rdDoneVec[i] = rdDoneValid && rdV[i] && (rdA[i] == rdDoneAddr);
      rdLive[i]    = rdV[i] && !rdDoneVec[i];
      rdMatch[i]   = rdLive[i] && (rdA[i] == reqAddr);
    end
    for (int i = RD_N - 1; i >= 0; i--) begin
      if (!rdLive[i]) begin rdHasFree = 1'b1; rdFreeIdx = RI_W'(i); end
      if (rdMatch[i]) begin rdHit = 1'b1; rdHitIdx = RI_W'(i); end
    end
    rdDoneHit      = |rdDoneVec;
    rdHitSpec      = (rdK[rdHitIdx] == K_SPEC);
    rdHitMergeFull = (int'(rdM[rdHitIdx]) >= MERGE_MAX);
  end

  // Write side lookups
  always_comb begin
    wrHit = 1'b0; wrHasFree = 1'b0; wrFreeIdx = '0; wrDoneKind = K_STORE;
    for (int i = 0; i < WR_N; i++) begin
      wrDoneVec[i] = wrDoneValid && wrV[i] && (wrA[i] == wrDoneAddr);
      wrLive[i]    = wrV[i] && !wrDoneVec[i];
      wrMatch[i]   = wrLive[i] && (wrA[i] == reqAddr);
    end
    for (int i = WR_N - 1; i >= 0; i--) begin
      if (!wrLive[i]) begin wrHasFree = 1'b1; wrFreeIdx = WI_W'(i); end
      if (wrMatch[i]) wrHit = 1'b1;
      if (wrDoneVec[i]) wrDoneKind = wrK[i];
    end
    wrDoneHit = |wrDoneVec;
  end

  // Age scan and occupancy
  always_comb begin
    anyStale   = 1'b0;
    validCount = '0;
    for (int i = 0; i < RD_N; i++) begin
      if (rdV[i] && ((nowTs - rdT[i]) >= TS_W'(THRESH))) anyStale = 1'b1;
      validCount = validCount + CNT_W'(rdV[i]);
    end
    for (int i = 0; i < WR_N; i++) begin
      if (wrV[i] && ((nowTs - wrT[i]) >= TS_W'(THRESH))) anyStale = 1'b1;
      validCount = validCount + CNT_W'(wrV[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nowTs <= '0;
      rdV   <= '0;
      wrV   <= '0;
      for (int i = 0; i < RD_N; i++) begin
        rdA[i] <= '0; rdK[i] <= K_LOAD; rdT[i] <= '0; rdM[i] <= '0;
      end
      for (int i = 0; i < WR_N; i++) begin
        wrA[i] <= '0; wrK[i] <= K_STORE; wrT[i] <= '0;
      end
    end else begin
      nowTs <= nowTs + 1'b1;
      for (int i = 0; i < RD_N; i++) begin
        if (stb.freeRd && rdDoneVec[i]) rdV[i] <= 1'b0;
        if (stb.mergeRd && (rdHitIdx == RI_W'(i))) rdM[i] <= rdM[i] + 1'b1;
        if (stb.allocRd && (rdFreeIdx == RI_W'(i))) begin
          rdV[i] <= 1'b1; rdA[i] <= reqAddr; rdK[i] <= reqKind;
          rdT[i] <= nowTs; rdM[i] <= '0;
        end
      end
      for (int i = 0; i < WR_N; i++) begin
        if (stb.freeWr && wrDoneVec[i]) wrV[i] <= 1'b0;
        if (stb.allocWr && (wrFreeIdx == WI_W'(i))) begin
          wrV[i] <= 1'b1; wrA[i] <= reqAddr; wrK[i] <= reqKind; wrT[i] <= nowTs;
        end
      end
    end
  end

  // R3: one write entry per line at most
  a_r3_wr_unique: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wrMatch));
  // R4: one read entry per line at most
  a_r4_rd_unique: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rdMatch));
  // R4: a line never sits in both tables
  a_r4_cross_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !((|rdMatch) && (|wrMatch)));

endmodule

// File: rtl/reqtrk_ctrl.sv
module reqtrk_ctrl
  import reqtrk_pkg::*;
#(
  parameter int ADDR_W  = 26,
  parameter int MAX_OUT = 16,
  parameter int THRESH  = 500000,
  parameter int CNT_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  kind_e             reqKind,
  input  logic              rdDoneValid,
  input  logic              wrDoneValid,
  input  logic [ADDR_W-1:0] wrDoneAddr,
  input  logic              rdHit,
  input  logic              rdHitSpec,
  input  logic              rdHitMergeFull,
  input  logic              wrHit,
  input  logic              rdHasFree,
  input  logic              wrHasFree,
  input  logic              rdDoneHit,
  input  logic              wrDoneHit,
  input  kind_e             wrDoneKind,
  input  logic              anyStale,
  input  logic [CNT_W-1:0]  validCount,
  output strobe_t           stb,
  output status_e           reqStatus,
  output logic [CNT_W-1:0]  outCount,
  output logic              lineLocked,
  output logic              deadlock,
  output logic              missError
);

  localparam int WD_W = $clog2(THRESH + 1);

  logic [ADDR_W-1:0] lockAddr, lockAddrN;
  logic              lockN;
  logic [CNT_W-1:0]  cntAfter;
  logic [WD_W-1:0]   wdCnt;
  logic              lockHit;

  // Lock state after this cycle's write completion
  always_comb begin
    lockN     = lineLocked;
    lockAddrN = lockAddr;
    if (wrDoneValid && wrDoneHit) begin
      if (wrDoneKind == K_LOCKRD) begin
        lockN = 1'b1; lockAddrN = wrDoneAddr;
      end else if (wrDoneKind == K_LOCKWR && lineLocked && lockAddr == wrDoneAddr) begin
        lockN = 1'b0;
      end
    end
  end

  // Verdict for the offered request, completions applied first
  always_comb begin
    stb        = '0;
    stb.freeRd = rdDoneValid && rdDoneHit;
    stb.freeWr = wrDoneValid && wrDoneHit;
    cntAfter   = outCount - CNT_W'(stb.freeRd) - CNT_W'(stb.freeWr);
    lockHit    = lockN && (lockAddrN == reqAddr);
    reqStatus  = ST_ISSUED;
    if (int'(cntAfter) >= MAX_OUT) begin
      reqStatus = ST_FULL;
    end else if (lockHit && reqKind != K_LOCKWR) begin
      reqStatus = ST_ALIASED;
    end else if (isStoreClass(reqKind)) begin
      if (rdHit || wrHit)  reqStatus = ST_ALIASED;
      else if (!wrHasFree) reqStatus = ST_FULL;
      else                 stb.allocWr = reqValid;
    end else begin
      if (wrHit) reqStatus = ST_ALIASED;
      else if (rdHit) begin
        if (reqKind == K_SPEC && rdHitSpec && !rdHitMergeFull) begin
          reqStatus = ST_MERGED; stb.mergeRd = reqValid;
        end else reqStatus = ST_ALIASED;
      end
      else if (!rdHasFree) reqStatus = ST_FULL;
      else                 stb.allocRd = reqValid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outCount   <= '0;
      lineLocked <= 1'b0;
      lockAddr   <= '0;
      deadlock   <= 1'b0;
      missError  <= 1'b0;
      wdCnt      <= '0;
    end else begin
      outCount   <= cntAfter + CNT_W'(stb.allocRd) + CNT_W'(stb.allocWr);
      lineLocked <= lockN;
      lockAddr   <= lockAddrN;
      if ((rdDoneValid && !rdDoneHit) || (wrDoneValid && !wrDoneHit)) missError <= 1'b1;
      if (outCount != '0) begin
        if (wdCnt == WD_W'(THRESH - 1)) begin
          wdCnt <= '0;
          if (anyStale) deadlock <= 1'b1;
        end else begin
          wdCnt <= wdCnt + 1'b1;
        end
      end else begin
        wdCnt <= '0;
      end
    end
  end

  // R7: the counter tracks the table occupancy
  a_r7_count_match: assert property (@(posedge clk) disable iff (!rst_n)
    outCount == validCount);
  // R1: occupancy never exceeds the limit
  a_r1_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(outCount) <= MAX_OUT);
  // R6: a completed locked read leaves its line locked
  a_r6_lock_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wrDoneValid && wrDoneHit && wrDoneKind == K_LOCKRD) |=> lineLocked);
  // R8: deadlock is sticky
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    deadlock |=> deadlock);
  // R9: the error flag is sticky
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    missError |=> missError);

endmodule

// File: rtl/line_request_tracker.sv
module line_request_tracker
  import reqtrk_pkg::*;
#(
  parameter int ADDR_W    = 26,
  parameter int RD_N      = 8,
  parameter int WR_N      = 8,
  parameter int MAX_OUT   = 16,
  parameter int MERGE_MAX = 4,
  parameter int THRESH    = 500000,
  localparam int CNT_W    = $clog2(RD_N + WR_N + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [3:0]        reqKind,
  output logic [1:0]        reqStatus,
  input  logic              rdDoneValid,
  input  logic [ADDR_W-1:0] rdDoneAddr,
  input  logic              wrDoneValid,
  input  logic [ADDR_W-1:0] wrDoneAddr,
  output logic [CNT_W-1:0]  outCount,
  output logic              lineLocked,
  output logic              deadlock,
  output logic              missError
);

  strobe_t          stb;
  status_e          statusE;
  kind_e            kindE, wrDoneKind;
  logic             rdHit, rdHitSpec, rdHitMergeFull, wrHit;
  logic             rdHasFree, wrHasFree, rdDoneHit, wrDoneHit, anyStale;
  logic [CNT_W-1:0] validCount;

  assign kindE     = kind_e'(reqKind);
  assign reqStatus = statusE;

  reqtrk_table #(
    .ADDR_W(ADDR_W), .RD_N(RD_N), .WR_N(WR_N), .MERGE_MAX(MERGE_MAX),
    .THRESH(THRESH), .CNT_W(CNT_W)
  ) uTable (
    .clk(clk), .rst_n(rst_n), .stb(stb), .reqAddr(reqAddr), .reqKind(kindE),
    .rdDoneValid(rdDoneValid), .rdDoneAddr(rdDoneAddr),
    .wrDoneValid(wrDoneValid), .wrDoneAddr(wrDoneAddr),
    .rdHit(rdHit), .rdHitSpec(rdHitSpec), .rdHitMergeFull(rdHitMergeFull),
    .wrHit(wrHit), .rdHasFree(rdHasFree), .wrHasFree(wrHasFree),
    .rdDoneHit(rdDoneHit), .wrDoneHit(wrDoneHit), .wrDoneKind(wrDoneKind),
    .anyStale(anyStale), .validCount(validCount)
  );

  reqtrk_ctrl #(
    .ADDR_W(ADDR_W), .MAX_OUT(MAX_OUT), .THRESH(THRESH), .CNT_W(CNT_W)
  ) uCtrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqKind(kindE), .rdDoneValid(rdDoneValid), .wrDoneValid(wrDoneValid),
    .wrDoneAddr(wrDoneAddr), .rdHit(rdHit), .rdHitSpec(rdHitSpec),
    .rdHitMergeFull(rdHitMergeFull), .wrHit(wrHit), .rdHasFree(rdHasFree),
    .wrHasFree(wrHasFree), .rdDoneHit(rdDoneHit), .wrDoneHit(wrDoneHit),
    .wrDoneKind(wrDoneKind), .anyStale(anyStale), .validCount(validCount),
    .stb(stb), .reqStatus(statusE), .outCount(outCount),
    .lineLocked(lineLocked), .deadlock(deadlock), .missError(missError)
  );

endmodule

// File: tb/tb_line_request_tracker.sv
module tb_line_request_tracker;

  localparam int AW = 4, RDN = 2, WRN = 2, MAXO = 3, MMAX = 2, TH = 16;
  localparam int CW = $clog2(RDN + WRN + 1);

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          reqValid = 1'b0, rdDoneValid = 1'b0, wrDoneValid = 1'b0;
  logic [AW-1:0] reqAddr = '0, rdDoneAddr = '0, wrDoneAddr = '0;
  logic [3:0]    reqKind = '0;
  logic [1:0]    reqStatus;
  logic [CW-1:0] outCount;
  logic          lineLocked, deadlock, missError;
  int            checks = 0, errors = 0;
  bit            finished = 1'b0;

  always #4 clk = ~clk;

  line_request_tracker #(.ADDR_W(AW), .RD_N(RDN), .WR_N(WRN), .MAX_OUT(MAXO),
                         .MERGE_MAX(MMAX), .THRESH(TH)) dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqKind(reqKind), .reqStatus(reqStatus), .rdDoneValid(rdDoneValid),
    .rdDoneAddr(rdDoneAddr), .wrDoneValid(wrDoneValid), .wrDoneAddr(wrDoneAddr),
    .outCount(outCount), .lineLocked(lineLocked), .deadlock(deadlock),
    .missError(missError));

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic issue(int kind, int addr, output int st);
    @(negedge clk);
    reqValid = 1'b1; reqKind = 4'(kind); reqAddr = AW'(addr);
    #1 st = int'(reqStatus);
    @(posedge clk); #1 reqValid = 1'b0;
  endtask

  task automatic doneRd(int addr);
    @(negedge clk); rdDoneValid = 1'b1; rdDoneAddr = AW'(addr);
    @(posedge clk); #1 rdDoneValid = 1'b0;
  endtask

  task automatic doneWr(int addr);
    @(negedge clk); wrDoneValid = 1'b1; wrDoneAddr = AW'(addr);
    @(posedge clk); #1 wrDoneValid = 1'b0;
  endtask

  function automatic int model(int p, int q, bit same);
    if (!same) return 0;
    if (q >= 3 || p >= 3) return 2;
    if (p == 1 && q == 1) return 1;
    return 2;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int st;
    doReset();
    @(negedge clk);
    check("R11 outCount", int'(outCount), 0);
    check("R11 lineLocked", int'(lineLocked), 0);
    check("R11 deadlock", int'(deadlock), 0);
    check("R11 missError", int'(missError), 0);

    // R3 R4 sweep: pending kind vs new kind, same line and other line
    for (int p = 0; p < 10; p++)
      for (int q = 0; q < 10; q++)
        for (int s = 0; s < 2; s++) begin
          int e;
          doReset();
          issue(p, 5, st);
          check("R3/R4 first issue", st, 0);
          e = model(p, q, bit'(s));
          issue(q, (s != 0) ? 5 : 9, st);
          check((q >= 3) ? "R3 store verdict" : "R4 load verdict", st, e);
          @(negedge clk);
          check("R7 count after pair", int'(outCount), (e == 0) ? 2 : 1);
        end

    // R1: read table exhaustion, then count limit
    doReset();
    issue(0, 1, st); check("R1 ld1", st, 0);
    issue(0, 2, st); check("R1 ld2", st, 0);
    issue(0, 3, st); check("R1 no read slot", st, 3);
    issue(3, 4, st); check("R1 st1", st, 0);
    issue(3, 6, st); check("R1 count at max", st, 3);
    @(negedge clk); check("R1 count unchanged", int'(outCount), 3);
    doneRd(1);
    @(negedge clk); check("R7 count after completion", int'(outCount), 2);

    // R5: merge limit
    doReset();
    issue(1, 7, st); check("R5 spec issue", st, 0);
    issue(1, 7, st); check("R5 merge 1", st, 1);
    issue(1, 7, st); check("R5 merge 2", st, 1);
    issue(1, 7, st); check("R5 merge over limit", st, 2);
    @(negedge clk); check("R7 merges add nothing", int'(outCount), 1);

    // R6 R2: lock and release
    doReset();
    issue(7, 7, st); check("R6 locked read issue", st, 0);
    doneWr(7);
    @(negedge clk); check("R6 locked", int'(lineLocked), 1);
    issue(0, 7, st); check("R2 load on locked line", st, 2);
    issue(3, 7, st); check("R2 store on locked line", st, 2);
    issue(0, 8, st); check("R2 other line", st, 0);
    issue(8, 7, st); check("R2 locked write allowed", st, 0);
    doneWr(7);
    @(negedge clk); check("R6 released", int'(lineLocked), 0);
    issue(0, 7, st); check("R6 line free again", st, 0);

    // R10: completion and conflicting request in the same cycle
    doReset();
    issue(0, 3, st);
    @(negedge clk);
    rdDoneValid = 1'b1; rdDoneAddr = 4'd3;
    reqValid = 1'b1; reqKind = 4'd3; reqAddr = 4'd3;
    #1 check("R10 alias cleared by completion", int'(reqStatus), 0);
    @(posedge clk); #1 rdDoneValid = 1'b0; reqValid = 1'b0;
    @(negedge clk); check("R10 count", int'(outCount), 1);
    issue(0, 1, st); issue(0, 2, st);
    @(negedge clk);
    wrDoneValid = 1'b1; wrDoneAddr = 4'd3;
    reqValid = 1'b1; reqKind = 4'd3; reqAddr = 4'd4;
    #1 check("R10 full cleared by completion", int'(reqStatus), 0);
    @(posedge clk); #1 wrDoneValid = 1'b0; reqValid = 1'b0;
    @(negedge clk); check("R10 count at max", int'(outCount), 3);

    // R9: unmatched completions
    doReset();
    issue(0, 2, st);
    doneWr(2);
    @(negedge clk);
    check("R9 wrong table flagged", int'(missError), 1);
    check("R9 entry kept", int'(outCount), 1);
    doReset();
    doneRd(5);
    @(negedge clk); check("R9 empty read flagged", int'(missError), 1);

    // R8: watchdog
    doReset();
    for (int k = 0; k < 5; k++) begin
      issue(0, 2, st);
      repeat (TH - 4) @(posedge clk);
      doneRd(2);
    end
    @(negedge clk); check("R8 no flag for young entries", int'(deadlock), 0);
    issue(3, 1, st);
    repeat (2 * TH + 2) @(posedge clk);
    @(negedge clk); check("R8 stuck entry flagged", int'(deadlock), 1);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule